// File: doc/BRIEF.md
# One-Time Programmable Security Register Space

This block holds a 128-byte security register space beside a serial memory's main array. The lower half is a 64-byte user area that software may program exactly once. The upper half is a unique identifier that is fixed when the design is built. The block keeps the user bytes and a lock flag. It answers read requests and takes write commits from the page-write sequencer. It also tells that sequencer where the shared address pointer must move after each access.

A commit delivers a start address, a write-protect level sampled at the end of the write, a byte count from 0 to 64, and the collected bytes in the order they were sent. Only the low six address bits choose the first user slot. Later bytes wrap inside the user area and never reach the identifier bytes. The first commit that actually stores data locks the whole user area, even if it wrote a single byte. A commit blocked by write protect stores nothing and leaves the area writable.

Reads decode seven pointer bits, so they reach both halves. The full-width pointer still steps by one. Because the pointer is shared with the main array, the step and wrap results are returned to the sequencer and are not kept here.

Top module: `otp_secreg`

## Requirements
- R1: After reset, `locked` equals the LOCK_INIT parameter, `rd_valid` is low, and every user byte reads 8'hFF.
- R2: An effective commit stores data byte i (bits 8i+7..8i of `cmt_data`) into user slot (`cmt_addr[5:0]` + i) mod 64, for each i below `cmt_count`. Address bits above bit 5 are ignored, so address 128 stores at slot 0. Slots outside that range keep their values.
- R3: A commit is effective when `cmt_wp` is 0, the block is unlocked and `cmt_count` is nonzero. One cycle after an effective commit, `locked` is 1, and it stays 1 until reset.
- R4: A commit with `cmt_wp` = 1 changes no user byte and does not set `locked`, so a later unprotected commit still stores.
- R5: A commit arriving while `locked` is 1 is accepted, changes no user byte, and `locked` stays 1.
- R6: A commit with `cmt_count` = 0 changes nothing and does not set `locked`.
- R7: A read request at one clock edge sets `rd_valid` for one cycle after that edge and places the byte at index `rd_ptr[6:0]` on `rd_data`. Indices 0..63 return user slots. Index 64+j returns identifier byte j, which is bits 8j+7..8j of FACTORY_ID.
- R8: `rd_ptr_next` is `rd_ptr` + 1 over the full 16-bit pointer and wraps to 0 after 16'hFFFF. It is combinational.
- R9: `wr_ptr_next` keeps `cmt_addr[15:6]` and sets its low six bits to (`cmt_addr[5:0]` + `cmt_count`) mod 64. It does this whatever the write-protect and lock state. It is combinational.
- R10: When a read and an effective commit arrive at the same edge, the read returns the byte as it was before the commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset, restores the as-built state |
| cmt_valid | input | 1 | One-cycle write commit strobe |
| cmt_addr | input | 16 | Pointer value at the start of the write |
| cmt_data | input | 512 | Collected bytes, byte i in bits 8i+7..8i |
| cmt_count | input | 7 | Number of bytes to store, 0..64 |
| cmt_wp | input | 1 | Write-protect level sampled at the end of the write |
| wr_ptr_next | output | 16 | Pointer value after the write, wrapped within the area |
| rd_req | input | 1 | Read request strobe |
| rd_ptr | input | 16 | Shared pointer for the read |
| rd_valid | output | 1 | Read data is present |
| rd_data | output | 8 | Byte read |
| rd_ptr_next | output | 16 | Pointer value after the read |
| locked | output | 1 | User area is locked |

## Verification
The bench builds the block with LOCK_INIT = 0, so the one-time write can be exercised from reset. It also passes a FACTORY_ID in which every identifier byte has a distinct computed value, so a wrong index in the upper half shows up as a wrong byte. Random upper pointer bits above the decoded range check that they are masked. A second reset gives the unlocked state back, which lets a full 64-byte wrapping write run after the first partial one has locked the area.

// File: rtl/otp_pkg.sv
package otp_pkg;

  typedef enum logic {
    REGION_USER    = 1'b0,
    REGION_FACTORY = 1'b1
  } otp_region_e;

  // Sum modulo a power-of-two ring size.
  function automatic int unsigned ring_add(int unsigned a, int unsigned b, int unsigned n);
    return (a + b) & (n - 1);
  endfunction

  // Steps needed to go from 'from' forward to 'to' on a power-of-two ring.
  function automatic int unsigned ring_dist(int unsigned from, int unsigned to, int unsigned n);
    return (to + n - from) & (n - 1);
  endfunction

endpackage

// File: rtl/otp_commit_ctrl.sv
module otp_commit_ctrl #(
  parameter int unsigned PTR_W     = 16,
  parameter int unsigned USER_N    = 64,
  parameter bit          LOCK_INIT = 1'b0,
  localparam int unsigned SLOT_W   = $clog2(USER_N),
  localparam int unsigned CNT_W    = SLOT_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmt_valid,
  input  logic [PTR_W-1:0] cmt_addr,
  input  logic [CNT_W-1:0] cmt_count,
  input  logic             cmt_wp,
  output logic             wr_en,
  output logic [SLOT_W-1:0] wr_base,
  output logic [PTR_W-1:0] wr_ptr_next,
  output logic             locked
);

  logic lock_q;
  logic blocked_wp;
  logic blocked_lock;
  logic empty_commit;

  assign blocked_wp   = cmt_wp;
  assign blocked_lock = lock_q;
  assign empty_commit = (cmt_count == '0);
  assign wr_en        = cmt_valid && !blocked_wp && !blocked_lock && !empty_commit;
  assign wr_base      = cmt_addr[SLOT_W-1:0];

  always_comb begin
    wr_ptr_next = cmt_addr;
    wr_ptr_next[SLOT_W-1:0] = SLOT_W'(otp_pkg::ring_add(
      int'(cmt_addr[SLOT_W-1:0]), int'(cmt_count), USER_N));
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     lock_q <= LOCK_INIT;
    else if (wr_en) lock_q <= 1'b1;
  end

  assign locked = lock_q;

  a_r3_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> locked);

  a_r3_effective_locks: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> locked);

  a_r4_wp_keeps_open: assert property (@(posedge clk) disable iff (!rst_n)
    (cmt_valid && cmt_wp && !locked) |=> !locked);

  a_r6_empty_keeps_open: assert property (@(posedge clk) disable iff (!rst_n)
    (cmt_valid && cmt_count == '0 && !locked) |=> !locked);

endmodule

// File: rtl/otp_user_store.sv
module otp_user_store #(
  parameter int unsigned USER_N = 64,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned SLOT_W = $clog2(USER_N),
  localparam int unsigned CNT_W  = SLOT_W + 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [SLOT_W-1:0]        wr_base,
  input  logic [CNT_W-1:0]         wr_count,
  input  logic [USER_N*DATA_W-1:0] wr_data,
  output logic [USER_N*DATA_W-1:0] user_flat
);

  for (genvar k = 0; k < USER_N; k++) begin : g_slot
    logic [SLOT_W-1:0] off;
    logic              hit;
    logic [DATA_W-1:0] cell_q;

    assign off = SLOT_W'(otp_pkg::ring_dist(int'(wr_base), k, USER_N));
    assign hit = ({1'b0, off} < wr_count);

    always_ff @(posedge clk) begin
      if (!rst_n)             cell_q <= '1;
      else if (wr_en && hit)  cell_q <= wr_data[int'(off)*DATA_W +: DATA_W];
    end

    assign user_flat[k*DATA_W +: DATA_W] = cell_q;
  end

  a_r5_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(user_flat));

  a_r2_first_byte_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_base == '0) |=> user_flat[DATA_W-1:0] == $past(wr_data[DATA_W-1:0]));

endmodule

// File: rtl/otp_read_port.sv
module otp_read_port #(
  parameter int unsigned PTR_W  = 16,
  parameter int unsigned USER_N = 64,
  parameter int unsigned DATA_W = 8,
  parameter logic [USER_N*DATA_W-1:0] FACTORY_ID = '0,
  localparam int unsigned SLOT_W = $clog2(USER_N),
  localparam int unsigned IDX_W  = SLOT_W + 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     rd_req,
  input  logic [PTR_W-1:0]         rd_ptr,
  input  logic [USER_N*DATA_W-1:0] user_flat,
  output logic                     rd_valid,
  output logic [DATA_W-1:0]        rd_data,
  output logic [PTR_W-1:0]         rd_ptr_next
);

  otp_pkg::otp_region_e region;
  logic [SLOT_W-1:0]    slot;
  logic [DATA_W-1:0]    pick;

  assign region = otp_pkg::otp_region_e'(rd_ptr[IDX_W-1]);
  assign slot   = rd_ptr[SLOT_W-1:0];

  always_comb begin
    if (region == otp_pkg::REGION_FACTORY) pick = FACTORY_ID[int'(slot)*DATA_W +: DATA_W];
    else                                   pick = user_flat[int'(slot)*DATA_W +: DATA_W];
  end

  assign rd_ptr_next = rd_ptr + PTR_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_req;
      if (rd_req) rd_data <= pick;
    end
  end

  a_r7_valid_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rd_valid);

  a_r7_valid_only_on_req: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !rd_valid);

  a_r7_data_held_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_req && !$past(!rst_n)) |=> $stable(rd_data));

endmodule

// File: rtl/otp_secreg.sv
module otp_secreg #(
  parameter int unsigned PTR_W     = 16,
  parameter int unsigned USER_N    = 64,
  parameter int unsigned DATA_W    = 8,
  parameter bit          LOCK_INIT = 1'b0,
  parameter logic [USER_N*DATA_W-1:0] FACTORY_ID = {(USER_N*DATA_W/8){8'h5A}},
  localparam int unsigned SLOT_W   = $clog2(USER_N),
  localparam int unsigned CNT_W    = SLOT_W + 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cmt_valid,
  input  logic [PTR_W-1:0]         cmt_addr,
  input  logic [USER_N*DATA_W-1:0] cmt_data,
  input  logic [CNT_W-1:0]         cmt_count,
  input  logic                     cmt_wp,
  output logic [PTR_W-1:0]         wr_ptr_next,
  input  logic                     rd_req,
  input  logic [PTR_W-1:0]         rd_ptr,
  output logic                     rd_valid,
  output logic [DATA_W-1:0]        rd_data,
  output logic [PTR_W-1:0]         rd_ptr_next,
  output logic                     locked
);

  logic                     wr_en;
  logic [SLOT_W-1:0]        wr_base;
  logic [USER_N*DATA_W-1:0] user_flat;

  otp_commit_ctrl #(
    .PTR_W(PTR_W), .USER_N(USER_N), .LOCK_INIT(LOCK_INIT)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cmt_valid(cmt_valid), .cmt_addr(cmt_addr), .cmt_count(cmt_count), .cmt_wp(cmt_wp),
    .wr_en(wr_en), .wr_base(wr_base), .wr_ptr_next(wr_ptr_next), .locked(locked)
  );

  otp_user_store #(
    .USER_N(USER_N), .DATA_W(DATA_W)
  ) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_base(wr_base), .wr_count(cmt_count), .wr_data(cmt_data),
    .user_flat(user_flat)
  );

  otp_read_port #(
    .PTR_W(PTR_W), .USER_N(USER_N), .DATA_W(DATA_W), .FACTORY_ID(FACTORY_ID)
  ) u_rd (
    .clk(clk), .rst_n(rst_n),
    .rd_req(rd_req), .rd_ptr(rd_ptr), .user_flat(user_flat),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_ptr_next(rd_ptr_next)
  );

  a_r5_locked_blocks_store: assert property (@(posedge clk) disable iff (!rst_n)
    (cmt_valid && locked) |=> $stable(user_flat));

  a_r4_wp_blocks_store: assert property (@(posedge clk) disable iff (!rst_n)
    (cmt_valid && cmt_wp) |=> $stable(user_flat));

endmodule

// File: tb/otp_secreg_bench.sv
module otp_secreg_bench;

  localparam int N = 64;

  function automatic logic [7:0] fid_byte(int j);
    return 8'((j * 29 + 60) ^ (j << 2));
  endfunction

  function automatic logic [N*8-1:0] build_fid();
    logic [N*8-1:0] v;
    for (int j = 0; j < N; j++) v[j*8 +: 8] = fid_byte(j);
    return v;
  endfunction

  localparam logic [N*8-1:0] FID = build_fid();

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmt_valid = 1'b0;
  logic [15:0] cmt_addr = '0;
  logic [N*8-1:0] cmt_data = '0;
  logic [6:0]  cmt_count = '0;
  logic        cmt_wp = 1'b0;
  logic [15:0] wr_ptr_next;
  logic        rd_req = 1'b0;
  logic [15:0] rd_ptr = '0;
  logic        rd_valid;
  logic [7:0]  rd_data;
  logic [15:0] rd_ptr_next;
  logic        locked;

  int tests = 0;
  int fails = 0;
  bit done = 0;
  logic [7:0] model [N];

  always #2 clk = ~clk;

  otp_secreg #(.LOCK_INIT(1'b0), .FACTORY_ID(FID)) u_otp_secreg (
    .clk(clk), .rst_n(rst_n),
    .cmt_valid(cmt_valid), .cmt_addr(cmt_addr), .cmt_data(cmt_data),
    .cmt_count(cmt_count), .cmt_wp(cmt_wp), .wr_ptr_next(wr_ptr_next),
    .rd_req(rd_req), .rd_ptr(rd_ptr), .rd_valid(rd_valid), .rd_data(rd_data),
    .rd_ptr_next(rd_ptr_next), .locked(locked)
  );

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_wr_next(logic [15:0] a, int cnt);
    return (a & 16'hFFC0) | 16'((a + cnt) % 64);
  endfunction

  function automatic logic [7:0] exp_read(logic [15:0] p);
    int idx = p % 128;
    return (idx >= 64) ? fid_byte(idx - 64) : model[idx];
  endfunction

  task automatic apply_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
    for (int i = 0; i < N; i++) model[i] = 8'hFF;
  endtask

  task automatic read_check(logic [15:0] p, string tag);
    @(negedge clk);
    rd_req = 1'b1; rd_ptr = p;
    #1 check(rd_ptr_next == p + 16'd1, "R8 ptr step", rd_ptr_next, p + 16'd1);
    @(negedge clk);
    rd_req = 1'b0;
    check(rd_valid === 1'b1, "R7 valid", rd_valid, 1);
    check(rd_data === exp_read(p), tag, rd_data, exp_read(p));
    @(negedge clk);
    check(rd_valid === 1'b0, "R7 valid drop", rd_valid, 0);
  endtask

  task automatic sweep(string tag);
    for (int i = 0; i < 128; i++) read_check(16'(i) | 16'($urandom() & 16'hFF80), tag);
  endtask

  task automatic commit(logic [15:0] a, int cnt, bit wp, bit with_read, logic [15:0] rp);
    logic [N*8-1:0] d;
    bit eff;
    for (int i = 0; i < N; i++) d[i*8 +: 8] = 8'($urandom());
    @(negedge clk);
    cmt_valid = 1'b1; cmt_addr = a; cmt_count = 7'(cnt); cmt_wp = wp; cmt_data = d;
    rd_req = with_read; rd_ptr = rp;
    #1 check(wr_ptr_next == exp_wr_next(a, cnt), "R9 wr ptr", wr_ptr_next, exp_wr_next(a, cnt));
    eff = !wp && !locked && cnt != 0;
    @(negedge clk);
    cmt_valid = 1'b0; rd_req = 1'b0;
    if (with_read) check(rd_data === exp_read(rp), "R10 old data", rd_data, exp_read(rp));
    if (eff) for (int i = 0; i < cnt; i++) model[(a + i) % 64] = d[i*8 +: 8];
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    apply_reset();
    check(locked === 1'b0, "R1 lock init", locked, 0);
    check(rd_valid === 1'b0, "R1 valid init", rd_valid, 0);
    sweep("R1 R7 reset read");

    // R4: protected write stores nothing, no lock
    commit(16'h0045, 10, 1'b1, 1'b0, 0);
    @(negedge clk);
    check(locked === 1'b0, "R4 no lock", locked, 0);
    for (int i = 0; i < 64; i++) read_check(16'(i), "R4 unchanged");

    // R6: empty commit
    commit(16'h0010, 0, 1'b0, 1'b0, 0);
    @(negedge clk);
    check(locked === 1'b0, "R6 no lock", locked, 0);

    // R9: random pointer arithmetic
    for (int t = 0; t < 20; t++) begin
      @(negedge clk);
      cmt_addr = 16'($urandom()); cmt_count = 7'($urandom_range(0, 64)); cmt_wp = 1'b1;
      #1 check(wr_ptr_next == exp_wr_next(cmt_addr, int'(cmt_count)), "R9 random",
               wr_ptr_next, exp_wr_next(cmt_addr, int'(cmt_count)));
    end
    cmt_wp = 1'b0;

    // R8: pointer wraps at full width
    read_check(16'hFFFF, "R7 top pointer");

    // R2 R10: partial wrapping write at 128+60, read slot 60 same edge
    commit(16'd188, 5, 1'b0, 1'b1, 16'd60);
    check(locked === 1'b1, "R3 locks", locked, 1);
    for (int i = 0; i < 64; i++) read_check(16'(i) | 16'($urandom() & 16'hFF80), "R2 stored");

    // R5: later commits ignored
    commit(16'h0000, 64, 1'b0, 1'b0, 0);
    commit(16'h0021, 3, 1'b0, 1'b0, 0);
    @(negedge clk);
    check(locked === 1'b1, "R5 stays locked", locked, 1);
    for (int i = 0; i < 64; i++) read_check(16'(i), "R5 unchanged");

    // R1 again, then R4 followed by a full 64-byte wrap write
    apply_reset();
    check(locked === 1'b0, "R1 lock after reset", locked, 0);
    commit(16'h1234, 7, 1'b1, 1'b0, 0);
    commit(16'h1234, 64, 1'b0, 1'b0, 0);
    check(locked === 1'b1, "R4 later write locks R3", locked, 1);
    sweep("R2 full page");

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule